// File: doc/BRIEF.md
# Broadcast Router Test Response Comparator

This block is a test wrapper around a row of identical router instances. One test stream, carried as valid/ready beats, feeds every instance at once. Each scan chain of every router gets the same serial bit, and bit k of every router's data input gets the same broadcast bit. No expected responses are stored. The wrapper decides pass or fail by comparing the instances with each other. Each instance has a response vector made of its data output and its scan-chain outputs. XOR logic compares every instance's response vector against instance 0. A qualified disagreement sets a sticky error flag that goes off-chip as a single pin. The flag also latches the cycle number of the first disagreement.

A diagnosis control works on the same compare cycles. When it is enabled, the wrapper takes a bit-wise majority over all instances and accumulates a one-hot-per-router vector that marks each instance disagreeing with that majority. The routers are modelled as small identical sequential stubs. Each stub has a fault-injection hook on its outputs, so the compare and diagnosis paths can be exercised.

The stream has these back-pressure rules. A beat transfers on a rising clock edge where `pat_valid` and `pat_ready` are both high. `pat_ready` is low during reset and rises on the first edge after reset is released. After that it stays high. A source may hold `pat_valid` low for any number of cycles. No router state moves without a transfer.

Top module: `rts_bcast_wrap`

## Requirements
- R1: After reset `err_flag`, `err_cycle`, `diag_odd` and `obs_resp` are all zero. `pat_ready` is high from the first edge after reset is released.
- R2: A beat with `pat_scan_en`=1 shifts each chain c of every router by one place, with `pat_scan[c]` entering at the chain's first stage. The chain's last stage drives scan output c. With chain length L, a bit appears on the scan output after L shift beats.
- R3: A beat with `pat_scan_en`=0 is a capture beat. The data register becomes its left-rotate-by-one XOR `pat_data`. Each chain becomes its left-rotate-by-one with bit 0 XORed by the parity of the old data register.
- R4: A cycle without a transfer (`pat_valid`=0) leaves all router state, and thus `obs_resp`, unchanged.
- R5: Disagreements are only counted in cycles with `cmp_en`=1. With `cmp_en`=0 a disagreement has no effect on `err_flag`, `err_cycle` or `diag_odd`.
- R6: `err_flag` is set on the edge after a qualified disagreement and stays set until `clr` is sampled high. `clr` clears the flag, `err_cycle` and `diag_odd`, and wins over a disagreement in the same cycle.
- R7: `err_cycle` latches the free-running cycle count of the first qualified disagreement only. Later disagreements leave it unchanged.
- R8: The cycle count is 0 in the cycle after reset release or after a cycle with `clr` high. It rises by one per clock and saturates at 2^CYC_W-1.
- R9: While `diag_en` and `cmp_en` are high and a disagreement exists, `diag_odd` bit i is ORed with 1 when router i's response differs in any bit from the bit-wise majority of all routers.
- R10: `flt_inj[i]` corrupts only the outputs of router i. With `flt_kind`=0, data output bit 0 reads 1. With `flt_kind`=1, scan output 0 reads 0. `obs_resp` is router 0's response: data output in the upper DATA_W bits and scan outputs in the low SCAN_CHAINS bits. Removing the fault restores the fault-free value.
- R11: A majority bit is 1 only when more than half the routers carry 1. A tie resolves to 0.
- R12: With no fault injected, no disagreement is ever reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_valid | input | 1 | Test beat valid |
| pat_ready | output | 1 | Wrapper accepts a beat |
| pat_scan_en | input | 1 | 1 = shift beat, 0 = capture beat |
| pat_scan | input | SCAN_CHAINS | Broadcast serial bit per chain |
| pat_data | input | DATA_W | Broadcast data-input pattern |
| cmp_en | input | 1 | Qualifies cross-router comparison |
| diag_en | input | 1 | Enables majority-vote diagnosis |
| clr | input | 1 | Clears flag, first-cycle record and diagnosis |
| flt_inj | input | N_ROUTERS | Per-router fault injection enable |
| flt_kind | input | 1 | 0 = data bit 0 stuck high, 1 = scan out 0 stuck low |
| obs_resp | output | DATA_W+SCAN_CHAINS | Response vector of router 0 |
| err_flag | output | 1 | Sticky off-chip mismatch flag |
| err_cycle | output | CYC_W | Cycle count of the first mismatch |
| diag_odd | output | N_ROUTERS | Accumulated disagreeing-router vector |

## Verification
The bench drives a disagreement in the same cycle as `clr`. A design that let the disagreement win would show the flag still set after the clear. It keeps disagreements running after the first one. A design that re-latched the count on every mismatch would show `err_cycle` drifting. It splits two faulty routers against two healthy ones to hit the tie rule. A design with the wrong tie rule would flag the healthy pair instead of the faulty pair. It also idles past counter saturation, where a wrapping counter would report a small cycle number. It also injects faults while `cmp_en` is low and toggles the stream with `pat_valid` low. A design that ignored the qualifier would raise the flag, and one that ignored the handshake would move `obs_resp`.

// File: rtl/rts_pkg.sv
package rts_pkg;
  // Output fault applied to a router stub
  typedef enum logic {
    FLT_DOUT_HI = 1'b0,  // data output bit 0 forced high
    FLT_SCAN_LO = 1'b1   // scan output 0 forced low
  } flt_kind_e;
endpackage

// File: rtl/rts_router_stub.sv
module rts_router_stub
  import rts_pkg::*;
#(
  parameter int SCAN_CHAINS = 2,
  parameter int CHAIN_LEN   = 4,
  parameter int DATA_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step,
  input  logic                   scan_en,
  input  logic [SCAN_CHAINS-1:0] scan_in,
  input  logic [DATA_W-1:0]      data_in,
  input  logic                   flt_on,
  input  flt_kind_e              flt_kind,
  output logic [SCAN_CHAINS-1:0] scan_out,
  output logic [DATA_W-1:0]      data_out
);
  logic [DATA_W-1:0]      dout_q;
  logic [SCAN_CHAINS-1:0] so_raw;
  logic                   dpar;

  assign dpar = ^dout_q;

  // one shift register per scan chain
  for (genvar c = 0; c < SCAN_CHAINS; c++) begin : g_chain
    logic [CHAIN_LEN-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else if (step) begin
        if (scan_en)
          chain_q <= {chain_q[CHAIN_LEN-2:0], scan_in[c]};
        else
          chain_q <= {chain_q[CHAIN_LEN-2:0], chain_q[CHAIN_LEN-1] ^ dpar};
      end
    end
    assign so_raw[c] = chain_q[CHAIN_LEN-1];
  end

  // functional data register, updated on capture beats
  always_ff @(posedge clk) begin
    if (!rst_n)
      dout_q <= '0;
    else if (step && !scan_en)
      dout_q <= {dout_q[DATA_W-2:0], dout_q[DATA_W-1]} ^ data_in;
  end

  // fault hook on outputs only; internal state untouched
  always_comb begin
    scan_out = so_raw;
    data_out = dout_q;
    if (flt_on) begin
      if (flt_kind == FLT_DOUT_HI) data_out[0] = 1'b1;
      else                         scan_out[0] = 1'b0;
    end
  end
endmodule

// File: rtl/rts_xor_cmp.sv
module rts_xor_cmp #(
  parameter int N_ROUTERS = 4,
  parameter int RESP_W    = 10
) (
  input  logic [N_ROUTERS*RESP_W-1:0] resp_all,
  output logic                        mismatch,
  output logic [N_ROUTERS-1:0]        odd
);
  localparam int CNT_W = $clog2(N_ROUTERS + 1);

  logic [RESP_W-1:0] resp [N_ROUTERS];
  logic [RESP_W-1:0] maj;
  logic [N_ROUTERS-1:0] diff0;

  for (genvar i = 0; i < N_ROUTERS; i++) begin : g_unpack
    assign resp[i] = resp_all[i*RESP_W +: RESP_W];
  end

  // XOR of each instance against instance 0
  assign diff0[0] = 1'b0;
  for (genvar i = 1; i < N_ROUTERS; i++) begin : g_diff
    assign diff0[i] = |(resp[i] ^ resp[0]);
  end
  assign mismatch = |diff0;

  // bit-wise majority; ties resolve to 0
  for (genvar b = 0; b < RESP_W; b++) begin : g_maj
    logic [CNT_W-1:0] ones;
    always_comb begin
      ones = '0;
      for (int i = 0; i < N_ROUTERS; i++)
        ones = ones + CNT_W'(resp[i][b]);
    end
    assign maj[b] = (32'(ones) * 2) > N_ROUTERS;
  end

  for (genvar i = 0; i < N_ROUTERS; i++) begin : g_odd
    assign odd[i] = |(resp[i] ^ maj);
  end
endmodule

// File: rtl/rts_err_track.sv
module rts_err_track #(
  parameter int N_ROUTERS = 4,
  parameter int CYC_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_en,
  input  logic                 diag_en,
  input  logic                 clr,
  input  logic                 mismatch,
  input  logic [N_ROUTERS-1:0] odd,
  output logic                 err_flag,
  output logic [CYC_W-1:0]     err_cycle,
  output logic [N_ROUTERS-1:0] diag_odd
);
  localparam logic [CYC_W-1:0] CNT_MAX = '1;

  logic [CYC_W-1:0] cnt_q;
  logic             hit;

  assign hit = cmp_en && mismatch;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt_q <= '0;
    else if (cnt_q != CNT_MAX)
      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err_flag  <= 1'b0;
      err_cycle <= '0;
      diag_odd  <= '0;
    end else if (hit) begin
      err_flag <= 1'b1;
      if (!err_flag) err_cycle <= cnt_q;
      if (diag_en)   diag_odd  <= diag_odd | odd;
    end
  end
endmodule

// File: rtl/rts_bcast_wrap.sv
module rts_bcast_wrap
  import rts_pkg::*;
#(
  parameter int N_ROUTERS   = 4,
  parameter int SCAN_CHAINS = 2,
  parameter int CHAIN_LEN   = 4,
  parameter int DATA_W      = 8,
  parameter int CYC_W       = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pat_valid,
  output logic                          pat_ready,
  input  logic                          pat_scan_en,
  input  logic [SCAN_CHAINS-1:0]        pat_scan,
  input  logic [DATA_W-1:0]             pat_data,
  input  logic                          cmp_en,
  input  logic                          diag_en,
  input  logic                          clr,
  input  logic [N_ROUTERS-1:0]          flt_inj,
  input  logic                          flt_kind,
  output logic [DATA_W+SCAN_CHAINS-1:0] obs_resp,
  output logic                          err_flag,
  output logic [CYC_W-1:0]              err_cycle,
  output logic [N_ROUTERS-1:0]          diag_odd
);
  localparam int RESP_W = DATA_W + SCAN_CHAINS;

  logic                        ready_q;
  logic                        fire;
  logic [N_ROUTERS*RESP_W-1:0] resp_all;
  logic                        cmp_mismatch;
  logic [N_ROUTERS-1:0]        cmp_odd;
  flt_kind_e                   kind;

  assign kind = flt_kind_e'(flt_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign pat_ready = ready_q;
  assign fire      = pat_valid && ready_q;

  for (genvar i = 0; i < N_ROUTERS; i++) begin : g_rtr
    logic [SCAN_CHAINS-1:0] so;
    logic [DATA_W-1:0]      dout;
    rts_router_stub #(
      .SCAN_CHAINS(SCAN_CHAINS), .CHAIN_LEN(CHAIN_LEN), .DATA_W(DATA_W)
    ) u_rtr (
      .clk(clk), .rst_n(rst_n), .step(fire), .scan_en(pat_scan_en),
      .scan_in(pat_scan), .data_in(pat_data), .flt_on(flt_inj[i]),
      .flt_kind(kind), .scan_out(so), .data_out(dout)
    );
    assign resp_all[i*RESP_W +: RESP_W] = {dout, so};
  end

  assign obs_resp = resp_all[RESP_W-1:0];

  rts_xor_cmp #(.N_ROUTERS(N_ROUTERS), .RESP_W(RESP_W)) u_cmp (
    .resp_all(resp_all), .mismatch(cmp_mismatch), .odd(cmp_odd)
  );

  rts_err_track #(.N_ROUTERS(N_ROUTERS), .CYC_W(CYC_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .diag_en(diag_en), .clr(clr),
    .mismatch(cmp_mismatch), .odd(cmp_odd), .err_flag(err_flag),
    .err_cycle(err_cycle), .diag_odd(diag_odd)
  );
endmodule

// File: rtl/rts_bcast_chk.sv
module rts_bcast_chk #(
  parameter int N_ROUTERS = 4,
  parameter int CYC_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic [N_ROUTERS-1:0] flt_inj,
  input logic                 mismatch,
  input logic                 err_flag,
  input logic [CYC_W-1:0]     err_cycle,
  input logic [N_ROUTERS-1:0] diag_odd
);
  // R12
  no_false_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_inj == '0) |-> !mismatch);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> err_flag);
  // R6
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!err_flag && diag_odd == '0));
  // R7
  first_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> $stable(err_cycle));
  // R9
  diag_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_odd != '0) |-> err_flag);
endmodule

bind rts_bcast_wrap rts_bcast_chk #(.N_ROUTERS(N_ROUTERS), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .flt_inj(flt_inj),
  .mismatch(cmp_mismatch), .err_flag(err_flag), .err_cycle(err_cycle),
  .diag_odd(diag_odd)
);

// File: tb/tb_rts_bcast_wrap.sv
module tb_rts_bcast_wrap;
  localparam int N  = 4;
  localparam int SC = 2;
  localparam int CL = 4;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int RW = DW + SC;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pat_valid = 1'b0, pat_scan_en = 1'b0;
  logic [SC-1:0] pat_scan = '0;
  logic [DW-1:0] pat_data = '0;
  logic cmp_en = 1'b0, diag_en = 1'b0, clr = 1'b0;
  logic [N-1:0] flt_inj = '0;
  logic flt_kind = 1'b0;
  logic pat_ready, err_flag;
  logic [RW-1:0] obs_resp;
  logic [CW-1:0] err_cycle;
  logic [N-1:0] diag_odd;

  always #10 clk = ~clk;  // 50 MHz

  rts_bcast_wrap #(.N_ROUTERS(N), .SCAN_CHAINS(SC), .CHAIN_LEN(CL),
                   .DATA_W(DW), .CYC_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .pat_scan_en(pat_scan_en), .pat_scan(pat_scan), .pat_data(pat_data),
    .cmp_en(cmp_en), .diag_en(diag_en), .clr(clr), .flt_inj(flt_inj),
    .flt_kind(flt_kind), .obs_resp(obs_resp), .err_flag(err_flag),
    .err_cycle(err_cycle), .diag_odd(diag_odd)
  );

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit live = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [CL-1:0] m_chain [SC];
  logic [DW-1:0] m_dout;
  bit m_ready, m_flag;
  int m_ecyc, m_cnt;
  logic [N-1:0] m_odd;

  function automatic logic [DW-1:0] rotl_d(input logic [DW-1:0] v);
    return {v[DW-2:0], v[DW-1]};
  endfunction

  function automatic logic [RW-1:0] resp_of(input int i);
    logic [SC-1:0] so;
    logic [DW-1:0] d;
    for (int c = 0; c < SC; c++) so[c] = m_chain[c][CL-1];
    d = m_dout;
    if (flt_inj[i]) begin
      if (flt_kind == 1'b0) d[0] = 1'b1;
      else                  so[0] = 1'b0;
    end
    return {d, so};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < SC; c++) m_chain[c] = '0;
      m_dout = '0; m_ready = 0; m_flag = 0; m_ecyc = 0; m_cnt = 0; m_odd = '0;
    end else begin
      logic [RW-1:0] r [N];
      logic [RW-1:0] maj;
      logic [N-1:0] od;
      bit mm;
      bit par;
      mm = 0;
      for (int i = 0; i < N; i++) r[i] = resp_of(i);
      for (int i = 1; i < N; i++) if (r[i] != r[0]) mm = 1;
      for (int b = 0; b < RW; b++) begin
        int ones;
        ones = 0;
        for (int i = 0; i < N; i++) ones += r[i][b];
        maj[b] = (2 * ones > N);
      end
      for (int i = 0; i < N; i++) od[i] = (r[i] != maj);
      if (clr) begin
        m_flag = 0; m_ecyc = 0; m_odd = '0; m_cnt = 0;
      end else begin
        if (cmp_en && mm) begin
          if (!m_flag) m_ecyc = m_cnt;
          m_flag = 1;
          if (diag_en) m_odd |= od;
        end
        if (m_cnt < CMAX) m_cnt++;
      end
      if (pat_valid && m_ready) begin
        par = ^m_dout;
        for (int c = 0; c < SC; c++) begin
          if (pat_scan_en) m_chain[c] = {m_chain[c][CL-2:0], pat_scan[c]};
          else m_chain[c] = {m_chain[c][CL-2:0], m_chain[c][CL-1] ^ par};
        end
        if (!pat_scan_en) m_dout = rotl_d(m_dout) ^ pat_data;
      end
      m_ready = 1;
    end
  end

  // per-cycle comparison against the model, away from the edges
  always @(negedge clk) begin
    if (rst_n && live) begin
      #3;
      chk(pat_ready == m_ready, cur_req, "pat_ready", pat_ready, m_ready);
      chk(obs_resp == resp_of(0), cur_req, "obs_resp", obs_resp, resp_of(0));
      chk(err_flag == m_flag, cur_req, "err_flag", err_flag, m_flag);
      chk(err_cycle == m_ecyc, cur_req, "err_cycle", err_cycle, m_ecyc);
      chk(diag_odd == m_odd, cur_req, "diag_odd", diag_odd, m_odd);
    end
  end

  // drive one cycle of stream inputs; returns just after the edge
  task automatic step(input bit v, input bit se, input logic [SC-1:0] s,
                      input logic [DW-1:0] d);
    @(negedge clk);
    pat_valid = v; pat_scan_en = se; pat_scan = s; pat_data = d;
    @(posedge clk);
    #2;
  endtask

  task automatic dout_to_zero();
    logic [DW-1:0] z;
    @(negedge clk);
    z = rotl_d(m_dout);
    pat_valid = 1; pat_scan_en = 0; pat_scan = '0; pat_data = z;
    @(posedge clk);
    #2;
    pat_valid = 0;
  endtask

  task automatic pulse_clr();
    clr = 1;
    step(0, 1, '0, '0);
    clr = 0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [RW-1:0] saved;
    int ec;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    live = 1;
    step(0, 1, '0, '0);
    // R1 reset state
    chk(err_flag == 0, "R1", "err_flag", err_flag, 0);
    chk(err_cycle == 0, "R1", "err_cycle", err_cycle, 0);
    chk(diag_odd == 0, "R1", "diag_odd", diag_odd, 0);
    chk(obs_resp == 0, "R1", "obs_resp", obs_resp, 0);
    chk(pat_ready == 1, "R1", "pat_ready", pat_ready, 1);

    // R2 shift: bit enters chain 0, emerges after CL beats
    cur_req = "R2"; cmp_en = 1;
    step(1, 1, 2'b01, '0);
    for (int k = 1; k < CL; k++) step(1, 1, 2'b00, '0);
    chk(obs_resp[SC-1:0] == 2'b01, "R2", "scan out after L beats", obs_resp[SC-1:0], 2'b01);
    step(1, 1, 2'b10, '0);
    step(1, 1, 2'b11, '0);

    // R3 capture
    cur_req = "R3";
    dout_to_zero();
    step(1, 0, '0, 8'h5A);
    chk(obs_resp[RW-1:SC] == 8'h5A, "R3", "dout after capture", obs_resp[RW-1:SC], 8'h5A);
    step(1, 0, '0, 8'h0F);
    chk(obs_resp[RW-1:SC] == 8'hBB, "R3", "dout second capture", obs_resp[RW-1:SC], 8'hBB);
    for (int k = 0; k < 6; k++) step(1, k[0], SC'(k), DW'(k * 37 + 3));

    // R4 no transfer without valid
    cur_req = "R4";
    saved = obs_resp;
    step(0, 0, 2'b11, 8'hFF);
    step(0, 1, 2'b11, 8'h81);
    step(0, 0, 2'b01, 8'h33);
    chk(obs_resp == saved, "R4", "obs_resp held", obs_resp, saved);

    // R12 no false mismatch over fault-free traffic with compare on
    cur_req = "R12";
    chk(err_flag == 0, "R12", "flag fault-free", err_flag, 0);

    // R5 disagreement ignored while compare disabled
    cur_req = "R5";
    cmp_en = 0;
    dout_to_zero();
    flt_inj = 4'b0100; flt_kind = 0;
    repeat (3) step(0, 1, '0, '0);
    chk(err_flag == 0, "R5", "flag with cmp_en low", err_flag, 0);
    chk(diag_odd == 0, "R5", "diag with cmp_en low", diag_odd, 0);

    // R6 / R7 sticky flag and first-cycle record
    cur_req = "R7";
    cmp_en = 1;
    step(0, 1, '0, '0);
    chk(err_flag == 1, "R6", "flag set", err_flag, 1);
    ec = int'(err_cycle);
    chk(m_flag == 1, "R7", "model saw mismatch", m_flag, 1);
    repeat (5) step(0, 1, '0, '0);
    chk(int'(err_cycle) == ec, "R7", "err_cycle held", err_cycle, ec);
    cur_req = "R6";
    pulse_clr();
    chk(err_flag == 0, "R6", "clr wins over mismatch", err_flag, 0);
    chk(err_cycle == 0, "R6", "clr zeroes err_cycle", err_cycle, 0);
    step(0, 1, '0, '0);
    chk(err_flag == 1, "R6", "flag set again", err_flag, 1);
    chk(err_cycle == 0, "R8", "count 0 after clr", err_cycle, 0);

    // R10 fault at router 0 outputs only
    cur_req = "R10";
    cmp_en = 0; flt_inj = '0;
    pulse_clr();
    for (int k = 0; k < CL; k++) step(1, 1, 2'b11, '0);
    step(0, 1, '0, '0);
    flt_inj = 4'b0001; flt_kind = 1;
    step(0, 1, '0, '0);
    chk(obs_resp[0] == 0, "R10", "scan out 0 stuck low", obs_resp[0], 0);
    flt_inj = '0;
    step(0, 1, '0, '0);
    chk(obs_resp[0] == 1, "R10", "fault removed", obs_resp[0], 1);

    // R9 diagnosis single odd router
    cur_req = "R9";
    flt_inj = 4'b0010; flt_kind = 1; diag_en = 1; cmp_en = 1;
    repeat (2) step(0, 1, '0, '0);
    chk(diag_odd == 4'b0010, "R9", "diag one-hot", diag_odd, 4'b0010);

    // R11 tie resolves to 0
    cur_req = "R11";
    cmp_en = 0; flt_inj = '0;
    pulse_clr();
    dout_to_zero();
    flt_inj = 4'b1001; flt_kind = 0; cmp_en = 1;
    repeat (2) step(0, 1, '0, '0);
    chk(diag_odd == 4'b1001, "R11", "tie flags stuck-high pair", diag_odd, 4'b1001);

    // R8 counter saturation
    cur_req = "R8";
    cmp_en = 0; diag_en = 0; flt_inj = '0;
    pulse_clr();
    repeat (300) step(0, 1, '0, '0);
    flt_inj = 4'b0100; flt_kind = 0; cmp_en = 1;
    step(0, 1, '0, '0);
    chk(err_cycle == CW'(CMAX), "R8", "saturated count", err_cycle, CMAX);

    live = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule